// File: doc/BRIEF.md
# Low-Speed USB Device Transaction Response Controller

This block stands behind a low-speed USB packet receiver. Each time the receiver finishes a packet it raises a one-cycle end-of-packet strobe. With the strobe it presents the first two bytes of the packet, the packet length and the position of the packet in its byte buffer. From these the controller decides, in a single step, how the device answers. It may stay silent, request a handshake (ACK or NAK), or request transmission of the prepared transmit buffer.

The controller holds the small amount of transaction state that ties packets together. It keeps the active and pending device addresses, the PID of the last accepted SETUP or OUT token, and the length and offset of the received payload. It also keeps the length of the data waiting to be sent. A data packet is taken only when it follows an accepted SETUP or OUT token and the receive buffer is empty. An IN token is served only when transmit data is ready and no unread received packet is pending. When an IN token is served, the pending address becomes active. A busy input from the serial transmitter delays the decision until the line is free.

Top module: `usb_xact_ctrl`

## Requirements
- R1: A packet with a length below 3 bytes gets no reply. It is treated as ignored.
- R2: A PID with bit 1 clear is handled as a token. A PID with bit 1 set is handled as data or handshake.
- R3: A token is acted on only if bits 6:0 of the second byte equal the active device address. Bit 7 of that byte is not compared. A token that fails this check is ignored.
- R4: An addressed IN token (PID 0x69) is answered with NAK in two cases: the transmit length is zero, or a received payload is still held (receive length non-zero).
- R5: An IN token that is served requests a data send with pointer TXBUF_PTR (default 0) and length equal to the transmit length. In the same step the transmit length goes to zero and the pending address becomes the active address.
- R6: An addressed token other than IN (SETUP 0x2D, OUT 0xE1) is stored as the current token PID and gets no reply.
- R7: A data-or-handshake PID with bit 0 clear (ACK 0xD2, NAK 0x5A, STALL 0x1E) is ignored.
- R8: A data packet (DATA0 0xC3, DATA1 0x4B) is ignored when no token is stored. If the receive length is non-zero it gets NAK. Otherwise its length and offset are recorded and it gets ACK.
- R9: Every ignored packet clears the stored token PID, so a following data packet is ignored.
- R10: When the transmitter is idle and no decision is waiting, send_req pulses for exactly one cycle, in the cycle after the end-of-packet strobe. This lies far inside the 6.5 low-speed bit-time reply budget. Handshake codes are send_sel 01 = ACK (pointer ACK_PTR, default 12, length 1) and 10 = NAK (pointer NAK_PTR, default 13, length 1). Code 11 means data.
- R11: While tx_busy is high, a received packet is held and no reply is requested. The decision is made, and any reply requested, in the cycle after tx_busy falls.
- R12: After reset the active and pending addresses are 0, no token is stored, both buffer lengths are 0 and send_req is low.
- R13: rx_done empties the receive buffer. tx_wr loads the transmit length. addr_wr sets the pending address. If tx_wr and a served IN fall in the same cycle, tx_wr wins. If an accepted data packet and rx_done fall in the same cycle, the accepted packet wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | End-of-packet strobe from the receiver |
| pkt_pid | input | 8 | First byte of the packet (PID) |
| pkt_byte1 | input | 8 | Second byte of the packet |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_off | input | LEN_W | Position of the packet in the receive byte buffer |
| tx_busy | input | 1 | Serial transmitter is sending |
| rx_done | input | 1 | Consumer has read the received payload |
| tx_wr | input | 1 | Load a new transmit length |
| tx_wr_len | input | LEN_W | Transmit length to load |
| addr_wr | input | 1 | Write the pending device address |
| addr_wdata | input | 7 | Pending device address value |
| send_req | output | 1 | One-cycle request to send a reply |
| send_sel | output | 2 | Reply kind: 01 ACK, 10 NAK, 11 data |
| send_ptr | output | PTR_W | Start pointer of the bytes to send |
| send_len | output | LEN_W | Number of bytes to send |
| dev_addr | output | 7 | Active device address |
| rx_len | output | LEN_W | Held receive payload length (0 = empty) |
| rx_off | output | LEN_W | Held receive payload offset |
| tx_len | output | LEN_W | Transmit data length (0 = none ready) |

## Verification
The checker watches several behaviours on every cycle. Short packets never produce a reply. An idle-transmitter packet is always decided in the following cycle, and no request appears while the transmitter is busy. An ACK always comes with a previously empty receive buffer that becomes filled. A data send always copies the pending address and carries a non-zero length. Other behaviour depends on the order of packets and only the directed scenarios can show it: token-then-data pairing, the clearing of the stored token by ignored packets, the address mask, and the new address taking effect only after a served IN.

// File: rtl/usb_xact_pkg.sv
package usb_xact_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_ACK  = 2'b01,
        SEL_NAK  = 2'b10,
        SEL_DATA = 2'b11
    } send_sel_e;

    typedef enum logic [2:0] {
        ACT_IGNORE,
        ACT_STORE,
        ACT_NAK,
        ACT_ACK,
        ACT_DATA
    } act_e;

    localparam logic [7:0] PID_IN = 8'h69;

    typedef struct packed {
        logic too_short;
        logic is_token;
        logic is_in;
        logic is_hs;
        logic addr_ok;
    } pkt_class_t;

endpackage

// File: rtl/usb_pkt_classify.sv
module usb_pkt_classify
    import usb_xact_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int MIN_LEN = 3
) (
    input  logic [7:0]       pid,
    input  logic [7:0]       byte1,
    input  logic [LEN_W-1:0] len,
    input  logic [6:0]       dev_addr,
    output pkt_class_t       cls
);
    always_comb begin
        cls.too_short = (32'(len) < MIN_LEN);
        cls.is_token  = ~pid[1];
        cls.is_in     = (pid == PID_IN);
        cls.is_hs     = pid[1] & ~pid[0];
        cls.addr_ok   = (byte1[6:0] == dev_addr);
    end
endmodule

// File: rtl/usb_xact_decide.sv
module usb_xact_decide
    import usb_xact_pkg::*;
(
    input  pkt_class_t cls,
    input  logic       tok_held,
    input  logic       rx_held,
    input  logic       tx_ready,
    output act_e       act
);
    always_comb begin
        act = ACT_IGNORE;
        if (cls.too_short) begin
            act = ACT_IGNORE;
        end else if (cls.is_token) begin
            if (!cls.addr_ok)
                act = ACT_IGNORE;
            else if (cls.is_in)
                act = (tx_ready && !rx_held) ? ACT_DATA : ACT_NAK;
            else
                act = ACT_STORE;
        end else begin
            if (cls.is_hs)
                act = ACT_IGNORE;
            else if (!tok_held)
                act = ACT_IGNORE;
            else if (rx_held)
                act = ACT_NAK;
            else
                act = ACT_ACK;
        end
    end
endmodule

// File: rtl/usb_xact_ctrl.sv
module usb_xact_ctrl
    import usb_xact_pkg::*;
#(
    parameter int BUF_DEPTH = 11,
    parameter int PTR_W     = 4,
    parameter int MIN_LEN   = 3,
    parameter logic [PTR_W-1:0] TXBUF_PTR = 0,
    parameter logic [PTR_W-1:0] ACK_PTR   = 12,
    parameter logic [PTR_W-1:0] NAK_PTR   = 13,
    localparam int LEN_W = $clog2(BUF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [7:0]       pkt_pid,
    input  logic [7:0]       pkt_byte1,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] pkt_off,
    input  logic             tx_busy,
    input  logic             rx_done,
    input  logic             tx_wr,
    input  logic [LEN_W-1:0] tx_wr_len,
    input  logic             addr_wr,
    input  logic [6:0]       addr_wdata,
    output logic             send_req,
    output logic [1:0]       send_sel,
    output logic [PTR_W-1:0] send_ptr,
    output logic [LEN_W-1:0] send_len,
    output logic [6:0]       dev_addr,
    output logic [LEN_W-1:0] rx_len,
    output logic [LEN_W-1:0] rx_off,
    output logic [LEN_W-1:0] tx_len
);

    typedef struct packed {
        logic [6:0]       dev_addr;
        logic [6:0]       new_addr;
        logic [7:0]       tok_pid;
        logic [LEN_W-1:0] rx_len;
        logic [LEN_W-1:0] rx_off;
        logic [LEN_W-1:0] tx_len;
        logic             pend;
        logic [7:0]       p_pid;
        logic [7:0]       p_byte1;
        logic [LEN_W-1:0] p_len;
        logic [LEN_W-1:0] p_off;
        logic             send_req;
        send_sel_e        send_sel;
        logic [PTR_W-1:0] send_ptr;
        logic [LEN_W-1:0] send_len;
    } state_t;

    state_t st_q, st_d;

    // packet source: held packet first, otherwise the live strobe
    logic [7:0]       src_pid, src_byte1;
    logic [LEN_W-1:0] src_len, src_off;
    logic             have_pkt, take_pkt;
    pkt_class_t       cls;
    act_e             act;

    assign src_pid   = st_q.pend ? st_q.p_pid   : pkt_pid;
    assign src_byte1 = st_q.pend ? st_q.p_byte1 : pkt_byte1;
    assign src_len   = st_q.pend ? st_q.p_len   : pkt_len;
    assign src_off   = st_q.pend ? st_q.p_off   : pkt_off;
    assign have_pkt  = st_q.pend | pkt_valid;
    assign take_pkt  = have_pkt & ~tx_busy;

    usb_pkt_classify #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_classify (
        .pid      (src_pid),
        .byte1    (src_byte1),
        .len      (src_len),
        .dev_addr (st_q.dev_addr),
        .cls      (cls)
    );

    usb_xact_decide u_decide (
        .cls      (cls),
        .tok_held (st_q.tok_pid != 8'h00),
        .rx_held  (st_q.rx_len != '0),
        .tx_ready (st_q.tx_len != '0),
        .act      (act)
    );

    always_comb begin
        st_d          = st_q;
        st_d.send_req = 1'b0;
        st_d.send_sel = SEL_NONE;
        st_d.send_ptr = '0;
        st_d.send_len = '0;

        if (rx_done) st_d.rx_len   = '0;
        if (addr_wr) st_d.new_addr = addr_wdata;

        if (have_pkt && tx_busy && !st_q.pend) begin
            st_d.pend    = 1'b1;
            st_d.p_pid   = pkt_pid;
            st_d.p_byte1 = pkt_byte1;
            st_d.p_len   = pkt_len;
            st_d.p_off   = pkt_off;
        end

        if (take_pkt) begin
            st_d.pend = 1'b0;
            unique case (act)
                ACT_IGNORE: st_d.tok_pid = 8'h00;
                ACT_STORE:  st_d.tok_pid = src_pid;
                ACT_NAK: begin
                    st_d.send_req = 1'b1;
                    st_d.send_sel = SEL_NAK;
                    st_d.send_ptr = NAK_PTR;
                    st_d.send_len = LEN_W'(1);
                end
                ACT_ACK: begin
                    st_d.rx_len   = src_len;
                    st_d.rx_off   = src_off;
                    st_d.send_req = 1'b1;
                    st_d.send_sel = SEL_ACK;
                    st_d.send_ptr = ACK_PTR;
                    st_d.send_len = LEN_W'(1);
                end
                ACT_DATA: begin
                    st_d.send_req = 1'b1;
                    st_d.send_sel = SEL_DATA;
                    st_d.send_ptr = TXBUF_PTR;
                    st_d.send_len = st_q.tx_len;
                    st_d.tx_len   = '0;
                    st_d.dev_addr = st_q.new_addr;
                end
                default: st_d.tok_pid = 8'h00;
            endcase
        end

        if (tx_wr) st_d.tx_len = tx_wr_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.send_sel <= SEL_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign send_req = st_q.send_req;
    assign send_sel = st_q.send_sel;
    assign send_ptr = st_q.send_ptr;
    assign send_len = st_q.send_len;
    assign dev_addr = st_q.dev_addr;
    assign rx_len   = st_q.rx_len;
    assign rx_off   = st_q.rx_off;
    assign tx_len   = st_q.tx_len;

endmodule

// File: rtl/usb_xact_chk.sv
module usb_xact_chk #(
    parameter int LEN_W   = 4,
    parameter int MIN_LEN = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic [LEN_W-1:0] pkt_len,
    input logic             tx_busy,
    input logic             send_req,
    input logic [1:0]       send_sel,
    input logic [LEN_W-1:0] send_len,
    input logic [6:0]       dev_addr,
    input logic [6:0]       new_addr_q,
    input logic [LEN_W-1:0] rx_len,
    input logic             pend_q
);
    // R1: a short packet decided at once never causes a request
    p_short_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !tx_busy && !pend_q && 32'(pkt_len) < MIN_LEN) |=> !send_req);

    // R10: idle transmitter means the packet is decided in the next cycle
    p_prompt_decide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !tx_busy && !pend_q) |=> !pend_q);

    // R10: a request always carries a reply kind
    p_req_has_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |-> (send_sel != 2'b00));

    // R11: nothing is requested while the transmitter was busy
    p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> !send_req);

    // R8: ACK only when the buffer was empty and is now filled
    p_ack_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && send_sel == 2'b01) |-> ($past(rx_len) == '0 && rx_len != '0));

    // R5: data send adopts the pending address and has a length
    p_data_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && send_sel == 2'b11) |-> (dev_addr == $past(new_addr_q) && send_len != '0));
endmodule

bind usb_xact_ctrl usb_xact_chk #(
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .pkt_len    (pkt_len),
    .tx_busy    (tx_busy),
    .send_req   (send_req),
    .send_sel   (send_sel),
    .send_len   (send_len),
    .dev_addr   (dev_addr),
    .new_addr_q (st_q.new_addr),
    .rx_len     (rx_len),
    .pend_q     (st_q.pend)
);

// File: tb/tb_usb_xact_ctrl.sv
module tb_usb_xact_ctrl;
    localparam int LEN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pkt_valid = 1'b0;
    logic [7:0]       pkt_pid = '0;
    logic [7:0]       pkt_byte1 = '0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic [LEN_W-1:0] pkt_off = '0;
    logic             tx_busy = 1'b0;
    logic             rx_done = 1'b0;
    logic             tx_wr = 1'b0;
    logic [LEN_W-1:0] tx_wr_len = '0;
    logic             addr_wr = 1'b0;
    logic [6:0]       addr_wdata = '0;
    logic             send_req;
    logic [1:0]       send_sel;
    logic [3:0]       send_ptr;
    logic [LEN_W-1:0] send_len;
    logic [6:0]       dev_addr;
    logic [LEN_W-1:0] rx_len, rx_off, tx_len;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [7:0] P_IN = 8'h69, P_OUT = 8'hE1, P_SETUP = 8'h2D;
    localparam logic [7:0] P_D0 = 8'hC3, P_D1 = 8'h4B, P_ACK = 8'hD2;

    usb_xact_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_pid(pkt_pid),
        .pkt_byte1(pkt_byte1), .pkt_len(pkt_len), .pkt_off(pkt_off),
        .tx_busy(tx_busy), .rx_done(rx_done), .tx_wr(tx_wr), .tx_wr_len(tx_wr_len),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .send_req(send_req),
        .send_sel(send_sel), .send_ptr(send_ptr), .send_len(send_len),
        .dev_addr(dev_addr), .rx_len(rx_len), .rx_off(rx_off), .tx_len(tx_len)
    );

    always #2 clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one packet strobe; on return the decision is visible
    task automatic pkt(logic [7:0] pid, logic [7:0] b1, int len, int off);
        @(negedge clk);
        pkt_pid = pid; pkt_byte1 = b1;
        pkt_len = LEN_W'(len); pkt_off = LEN_W'(off);
        pkt_valid = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic expect_reply(string req, int sel, int ptr, int len);
        check({req, " send_req"}, int'(send_req), (sel != 0) ? 1 : 0);
        if (sel != 0) begin
            check({req, " send_sel"}, int'(send_sel), sel);
            check({req, " send_ptr"}, int'(send_ptr), ptr);
            check({req, " send_len"}, int'(send_len), len);
        end
    endtask

    task automatic load_tx(int len);
        @(negedge clk); tx_wr = 1'b1; tx_wr_len = LEN_W'(len);
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic free_rx();
        @(negedge clk); rx_done = 1'b1;
        @(negedge clk); rx_done = 1'b0;
    endtask

    task automatic set_addr(int a);
        @(negedge clk); addr_wr = 1'b1; addr_wdata = 7'(a);
        @(negedge clk); addr_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 dev_addr", int'(dev_addr), 0);
        check("R12 rx_len", int'(rx_len), 0);
        check("R12 tx_len", int'(tx_len), 0);
        check("R12 send_req", int'(send_req), 0);
    endtask

    task automatic t_short_and_orphan();
        pkt(P_IN, 8'h00, 2, 0);
        expect_reply("R1 short IN", 0, 0, 0);
        pkt(P_D0, 8'h00, 5, 1);
        expect_reply("R8 data without token", 0, 0, 0);
    endtask

    task automatic t_addr_mismatch();
        pkt(P_OUT, 8'h03, 3, 0);
        expect_reply("R3 foreign OUT", 0, 0, 0);
        pkt(P_D0, 8'h00, 5, 1);
        expect_reply("R3 data after foreign OUT", 0, 0, 0);
        check("R3 rx_len untouched", int'(rx_len), 0);
    endtask

    task automatic t_out_data();
        pkt(P_OUT, 8'h80, 3, 0);   // bit 7 set: still address 0
        expect_reply("R6 OUT silent", 0, 0, 0);
        pkt(P_D0, 8'h00, 7, 2);
        expect_reply("R8 R2 DATA0 ack", 1, 12, 1);
        check("R8 rx_len", int'(rx_len), 7);
        check("R8 rx_off", int'(rx_off), 2);
        @(negedge clk);
        check("R10 single pulse", int'(send_req), 0);
        pkt(P_D1, 8'h00, 4, 3);
        expect_reply("R8 full NAK", 2, 13, 1);
        check("R8 rx_len kept", int'(rx_len), 7);
    endtask

    task automatic t_in_nak();
        pkt(P_IN, 8'h00, 3, 0);
        expect_reply("R4 no tx data", 2, 13, 1);
        load_tx(5);
        check("R13 tx_len load", int'(tx_len), 5);
        pkt(P_IN, 8'h00, 3, 0);
        expect_reply("R4 rx held", 2, 13, 1);
        check("R4 tx_len kept", int'(tx_len), 5);
    endtask

    task automatic t_in_data();
        free_rx();
        check("R13 rx freed", int'(rx_len), 0);
        set_addr(9);
        check("R13 addr pending only", int'(dev_addr), 0);
        pkt(P_IN, 8'h00, 3, 0);
        expect_reply("R5 data send", 3, 0, 5);
        check("R5 tx_len cleared", int'(tx_len), 0);
        check("R5 new address", int'(dev_addr), 9);
        pkt(P_IN, 8'h00, 3, 0);
        expect_reply("R3 old address ignored", 0, 0, 0);
        pkt(P_IN, 8'h09, 3, 0);
        expect_reply("R4 new address nak", 2, 13, 1);
    endtask

    task automatic t_hs_clears();
        pkt(P_SETUP, 8'h09, 3, 0);
        expect_reply("R6 SETUP silent", 0, 0, 0);
        pkt(P_ACK, 8'h00, 3, 0);
        expect_reply("R7 ACK ignored", 0, 0, 0);
        pkt(P_D0, 8'h00, 5, 1);
        expect_reply("R9 token cleared", 0, 0, 0);
        check("R9 rx_len empty", int'(rx_len), 0);
    endtask

    task automatic t_busy();
        pkt(P_SETUP, 8'h09, 3, 0);
        @(negedge clk);
        tx_busy = 1'b1;
        pkt(P_D1, 8'h00, 6, 1);
        expect_reply("R11 held while busy", 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 still quiet", int'(send_req), 0);
        end
        tx_busy = 1'b0;
        @(negedge clk);
        expect_reply("R11 after busy", 1, 12, 1);
        check("R11 rx_len", int'(rx_len), 6);
    endtask

    task automatic t_short_clears();
        free_rx();
        pkt(P_OUT, 8'h09, 3, 0);
        pkt(P_D0, 8'h00, 2, 0);
        expect_reply("R1 short data", 0, 0, 0);
        pkt(P_D0, 8'h00, 5, 0);
        expect_reply("R1 R9 token gone", 0, 0, 0);
    endtask

    task automatic t_tx_wr_wins();
        // rx empty, tx loaded; IN served in the same cycle as a tx_wr
        load_tx(4);
        @(negedge clk);
        pkt_pid = P_IN; pkt_byte1 = 8'h09; pkt_len = 3; pkt_off = 0;
        pkt_valid = 1'b1; tx_wr = 1'b1; tx_wr_len = 4'd7;
        @(negedge clk);
        pkt_valid = 1'b0; tx_wr = 1'b0;
        expect_reply("R13 served IN", 3, 0, 4);
        check("R13 tx_wr wins", int'(tx_len), 7);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_and_orphan();
        t_addr_mismatch();
        t_out_data();
        t_in_nak();
        t_in_data();
        t_hs_clears();
        t_busy();
        t_short_clears();
        t_tx_wr_wins();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule